// File: doc/BRIEF.md
# Conditional Branch and Skip Sequencer

This block decides where program flow goes next for an 8-bit processor's conditional control-transfer instructions. It handles two opcode groups. The first group is the 0x30 to 0x3F short branches: two-byte instructions that jump within the current 256-byte page. The second group is the 0xC0 to 0xCF row, which holds three kinds of instruction: the long branches (three bytes, full 16-bit target), the long skips (one byte, step over two bytes) and a no-operation. When `start` is pulsed, the block captures the opcode, the program counter and the condition flags. It then runs one or two execute cycles. During those cycles it reads operand bytes through a simple byte-wide read port. At the end it reports the new program counter, whether the condition was met, and how many execute cycles were spent.

The value on `pc_in` is the address just after the opcode byte, which is the first operand byte if the instruction has one. For a short branch, only the low byte of the program counter is ever replaced. Long skips and the no-operation never touch memory. All arithmetic on the program counter wraps at 16 bits.

Top module: `branch_skip_seq`

## Requirements
- R1: While and right after reset, `done`, `rd_en` and `taken` are 0, `pc_out` is 0 and `exec_cycles` is 0.
- R2: For a short branch (opcode 0x3k), bits [2:0] pick the condition: 0 always, 1 `flag_q`, 2 `acc_zero`, 3 `flag_df`, 4 to 7 `ext_flag[0]` to `ext_flag[3]`. Bit 3 inverts the condition, so 0x38 never branches. All flags are sampled in the `start` cycle, and `taken` reports the result.
- R3: A short branch reads one byte at `pc_in` and takes one execute cycle. If taken, `pc_out` = {`pc_in`[15:8], byte}. If not taken, `pc_out` = `pc_in`+1 (mod 2^16).
- R4: Long branches are 0xC0 (always), 0xC1 (Q=1), 0xC2 (D=0), 0xC3 (DF=1), 0xC9 (Q=0), 0xCA (D≠0) and 0xCB (DF=0). Each reads bytes at `pc_in` and then at `pc_in`+1, and takes two execute cycles. If taken, `pc_out` = {first byte, second byte}. If not taken, `pc_out` = `pc_in`+2 (mod 2^16).
- R5: Long skips are 0xC5 (Q=0), 0xC6 (D≠0), 0xC7 (DF=0), 0xC8 (always), 0xCC (IE=1), 0xCD (Q=1), 0xCE (D=0) and 0xCF (DF=1). Each takes two execute cycles and never asserts `rd_en`. If the condition holds, `taken`=1 and `pc_out` = `pc_in`+2 (mod 2^16). Otherwise `taken`=0 and `pc_out` = `pc_in`.
- R6: 0xC4 takes two execute cycles, never reads memory, reports `taken`=0 and returns `pc_out` = `pc_in`.
- R7: `done` is a one-cycle pulse seen exactly `exec_cycles` cycles after the clock edge that accepted `start`. `pc_out`, `taken` and `exec_cycles` hold their values after the pulse.
- R8: An opcode outside 0x30 to 0x3F and 0xC0 to 0xCF is ignored: no `done`, no `rd_en`, and the outputs stay unchanged.
- R9: A `start` that arrives while an instruction is executing is ignored. The running instruction completes with its own values, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| opcode | input | 8 | Instruction byte |
| pc_in | input | 16 | Address of the byte after the opcode |
| flag_q | input | 1 | Q output flag |
| acc_zero | input | 1 | Accumulator equals zero |
| flag_df | input | 1 | Carry/borrow flag |
| int_en | input | 1 | Interrupt enable flag |
| ext_flag | input | 4 | External flag inputs 1 to 4 (bit 0 is flag 1) |
| rd_data | input | 8 | Byte returned for `rd_addr` in the same cycle |
| rd_en | output | 1 | Operand byte read in this cycle |
| rd_addr | output | 16 | Operand byte address |
| done | output | 1 | Result valid pulse |
| taken | output | 1 | Condition was met |
| pc_out | output | 16 | Next program counter value |
| exec_cycles | output | 2 | Execute cycles used (1 or 2) |

## Verification
The hardest situations to reach are the ones where the page-local replacement and 16-bit wraparound give different results from a plain add. Examples are a short branch with the operand at xxFF that is not taken, and a long branch or skip starting at 0xFFFE or 0xFFFF. The sweep reaches these by running every one of the 32 opcodes under all 256 combinations of the eight flags. The start address is derived from the flag pattern, so low bytes of 0xFF and high bytes of 0xFF occur, and explicit runs at 0xFFFF, 0xFFFE and 0x12FF are added. A start pulse placed deliberately in the middle of a two-cycle long branch covers the overlap case.

// File: rtl/br_seq_pkg.sv
package br_seq_pkg;
  localparam int OPC_W   = 8;
  localparam int NUM_EF  = 4;
  localparam int SEL_W   = 4;
  localparam int NCAND   = 2 ** SEL_W;

  // condition select codes
  localparam logic [SEL_W-1:0] COND_ALWAYS = 4'd0;
  localparam logic [SEL_W-1:0] COND_Q      = 4'd1;
  localparam logic [SEL_W-1:0] COND_ZERO   = 4'd2;
  localparam logic [SEL_W-1:0] COND_DF     = 4'd3;
  localparam logic [SEL_W-1:0] COND_EF0    = 4'd4;
  localparam logic [SEL_W-1:0] COND_IE     = 4'(4 + NUM_EF);

  typedef enum logic [1:0] {ST_IDLE, ST_EX1, ST_EX2} seq_state_e;
  typedef enum logic [2:0] {OP_NONE, OP_SBR, OP_LBR, OP_LSKP, OP_NOP} op_class_e;
endpackage

// File: rtl/br_seq_decode.sv
module br_seq_decode
  import br_seq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_class_e        op_class,
  output logic [SEL_W-1:0] cond_sel,
  output logic             cond_inv
);
  logic [1:0] low2;
  assign low2 = opcode[1:0];

  always_comb begin
    op_class = OP_NONE;
    cond_sel = COND_ALWAYS;
    cond_inv = 1'b0;
    case (opcode[7:4])
      4'h3: begin
        // short branch: three select bits, bit 3 inverts (R2)
        op_class = OP_SBR;
        cond_sel = {1'b0, opcode[2:0]};
        cond_inv = opcode[3];
      end
      4'hC: begin
        if (opcode[2]) begin
          if (low2 == 2'b00) begin
            if (opcode[3]) begin
              op_class = OP_LSKP;      // skip when interrupts enabled
              cond_sel = COND_IE;
            end else begin
              op_class = OP_NOP;       // never taken
              cond_sel = COND_ALWAYS;
              cond_inv = 1'b1;
            end
          end else begin
            op_class = OP_LSKP;        // Q / zero / DF, inverted in lower half
            cond_sel = {2'b00, low2};
            cond_inv = ~opcode[3];
          end
        end else if (opcode[3] && low2 == 2'b00) begin
          op_class = OP_LSKP;          // unconditional long skip
          cond_sel = COND_ALWAYS;
        end else begin
          op_class = OP_LBR;
          cond_sel = {2'b00, low2};
          cond_inv = opcode[3];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/br_seq_cond.sv
module br_seq_cond
  import br_seq_pkg::*;
(
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              cond_inv,
  input  logic              flag_q,
  input  logic              acc_zero,
  input  logic              flag_df,
  input  logic              int_en,
  input  logic [NUM_EF-1:0] ext_flag,
  output logic              hit
);
  logic [NCAND-1:0] cand;

  assign cand[COND_ALWAYS] = 1'b1;
  assign cand[COND_Q]      = flag_q;
  assign cand[COND_ZERO]   = acc_zero;
  assign cand[COND_DF]     = flag_df;
  assign cand[COND_IE]     = int_en;

  genvar g;
  generate
    for (g = 0; g < NUM_EF; g++) begin : g_ef
      assign cand[int'(COND_EF0) + g] = ext_flag[g];
    end
    for (g = int'(COND_IE) + 1; g < NCAND; g++) begin : g_pad
      assign cand[g] = 1'b0;
    end
  endgenerate

  assign hit = cand[cond_sel] ^ cond_inv;
endmodule

// File: rtl/br_seq_target.sv
module br_seq_target
  import br_seq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  op_class_e             op_class,
  input  logic                  hit,
  input  logic [2*BYTE_W-1:0]   pc,
  input  logic [BYTE_W-1:0]     hi_byte,
  input  logic [BYTE_W-1:0]     lo_byte,
  output logic [2*BYTE_W-1:0]   next_pc
);
  localparam int PC_W = 2 * BYTE_W;

  logic [PC_W-1:0] pc_p1, pc_p2;
  assign pc_p1 = pc + PC_W'(1);
  assign pc_p2 = pc + PC_W'(2);

  always_comb begin
    case (op_class)
      OP_SBR:  next_pc = hit ? {pc[PC_W-1:BYTE_W], lo_byte} : pc_p1;
      OP_LBR:  next_pc = hit ? {hi_byte, lo_byte} : pc_p2;
      OP_LSKP: next_pc = hit ? pc_p2 : pc;
      default: next_pc = pc;
    endcase
  end
endmodule

// File: rtl/branch_skip_seq.sv
module branch_skip_seq
  import br_seq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [OPC_W-1:0]      opcode,
  input  logic [2*BYTE_W-1:0]   pc_in,
  input  logic                  flag_q,
  input  logic                  acc_zero,
  input  logic                  flag_df,
  input  logic                  int_en,
  input  logic [NUM_EF-1:0]     ext_flag,
  input  logic [BYTE_W-1:0]     rd_data,
  output logic                  rd_en,
  output logic [2*BYTE_W-1:0]   rd_addr,
  output logic                  done,
  output logic                  taken,
  output logic [2*BYTE_W-1:0]   pc_out,
  output logic [1:0]            exec_cycles
);
  localparam int PC_W = 2 * BYTE_W;

  seq_state_e       state;
  op_class_e        dec_class, cls_q;
  logic [SEL_W-1:0] dec_sel;
  logic             dec_inv, dec_hit, hit_q;
  logic [PC_W-1:0]  pc_q, next_pc;
  logic [BYTE_W-1:0] hi_q;
  logic             accept;

  br_seq_decode u_decode (
    .opcode   (opcode),
    .op_class (dec_class),
    .cond_sel (dec_sel),
    .cond_inv (dec_inv)
  );

  br_seq_cond u_cond (
    .cond_sel (dec_sel),
    .cond_inv (dec_inv),
    .flag_q   (flag_q),
    .acc_zero (acc_zero),
    .flag_df  (flag_df),
    .int_en   (int_en),
    .ext_flag (ext_flag),
    .hit      (dec_hit)
  );

  br_seq_target #(.BYTE_W(BYTE_W)) u_target (
    .op_class (cls_q),
    .hit      (hit_q),
    .pc       (pc_q),
    .hi_byte  (hi_q),
    .lo_byte  (rd_data),
    .next_pc  (next_pc)
  );

  assign accept = (state == ST_IDLE) && start && (dec_class != OP_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cls_q       <= OP_NONE;
      hit_q       <= 1'b0;
      pc_q        <= '0;
      hi_q        <= '0;
      rd_en       <= 1'b0;
      rd_addr     <= '0;
      done        <= 1'b0;
      taken       <= 1'b0;
      pc_out      <= '0;
      exec_cycles <= 2'd0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cls_q   <= dec_class;
            hit_q   <= dec_hit;
            pc_q    <= pc_in;
            rd_addr <= pc_in;
            rd_en   <= (dec_class == OP_SBR) || (dec_class == OP_LBR);
            state   <= ST_EX1;
          end
        end
        ST_EX1: begin
          if (cls_q == OP_SBR) begin
            pc_out      <= next_pc;
            taken       <= hit_q;
            exec_cycles <= 2'd1;
            done        <= 1'b1;
            rd_en       <= 1'b0;
            state       <= ST_IDLE;
          end else begin
            hi_q    <= rd_data;
            rd_addr <= pc_q + PC_W'(1);
            state   <= ST_EX2;
          end
        end
        default: begin
          pc_out      <= next_pc;
          taken       <= hit_q;
          exec_cycles <= 2'd2;
          done        <= 1'b1;
          rd_en       <= 1'b0;
          state       <= ST_IDLE;
        end
      endcase
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: a taken short branch stays inside the operand's page
  assert_short_page_R3: assert property (@(posedge clk) disable iff (rst)
    (done && exec_cycles == 2'd1 && taken) |->
      (pc_out[PC_W-1:BYTE_W] == rd_addr[PC_W-1:BYTE_W]));

  // R3: an untaken short branch steps over its operand byte
  assert_short_step_R3: assert property (@(posedge clk) disable iff (rst)
    (done && exec_cycles == 2'd1 && !taken) |->
      (pc_out == rd_addr + PC_W'(1)));

  // R4: the second operand read follows the first
  assert_second_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EX2) |-> (rd_addr == PC_W'($past(rd_addr) + PC_W'(1))));

  // R5 / R6: skips and the no-op never request memory
  assert_skip_no_read_R5: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_IDLE) && (cls_q == OP_LSKP || cls_q == OP_NOP)) |-> !rd_en);

  // R9: no new instruction is captured while one is running
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EX1 && cls_q != OP_SBR) |=> (state == ST_EX2 && $stable(pc_q)));
endmodule

// File: tb/branch_skip_seq_tb.sv
module branch_skip_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pc_in = '0;
  logic        flag_q = 0, acc_zero = 0, flag_df = 0, int_en = 0;
  logic [3:0]  ext_flag = '0;
  logic [7:0]  rd_data;
  logic        rd_en, done, taken;
  logic [15:0] rd_addr, pc_out;
  logic [1:0]  exec_cycles;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign rd_data = memf(rd_addr);

  branch_skip_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .pc_in(pc_in),
    .flag_q(flag_q), .acc_zero(acc_zero), .flag_df(flag_df), .int_en(int_en),
    .ext_flag(ext_flag), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .done(done), .taken(taken), .pc_out(pc_out), .exec_cycles(exec_cycles)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // flag bits: [0] Q, [1] D==0, [2] DF, [3] IE, [7:4] EF1..EF4
  function automatic bit exp_hit(input logic [7:0] op, input logic [7:0] fl);
    bit q, z, df, ie;
    q = fl[0]; z = fl[1]; df = fl[2]; ie = fl[3];
    case (op)
      8'h30: return 1;       8'h31: return q;       8'h32: return z;
      8'h33: return df;      8'h34: return fl[4];   8'h35: return fl[5];
      8'h36: return fl[6];   8'h37: return fl[7];   8'h38: return 0;
      8'h39: return !q;      8'h3A: return !z;      8'h3B: return !df;
      8'h3C: return !fl[4];  8'h3D: return !fl[5];  8'h3E: return !fl[6];
      8'h3F: return !fl[7];
      8'hC0: return 1;       8'hC1: return q;       8'hC2: return z;
      8'hC3: return df;      8'hC4: return 0;       8'hC5: return !q;
      8'hC6: return !z;      8'hC7: return !df;     8'hC8: return 1;
      8'hC9: return !q;      8'hCA: return !z;      8'hCB: return !df;
      8'hCC: return ie;      8'hCD: return q;       8'hCE: return z;
      8'hCF: return df;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_lbr(input logic [7:0] op);
    return (op >= 8'hC0 && op <= 8'hC3) || (op >= 8'hC9 && op <= 8'hCB);
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] fl);
    bit h, sh, lb;
    string tg;
    logic [15:0] epc;
    int ecyc, cyc;
    logic en0, en1;
    logic [15:0] a0, a1;
    h  = exp_hit(op, fl);
    sh = (op[7:4] == 4'h3);
    lb = is_lbr(op);
    if (sh)             begin tg = "R3"; ecyc = 1; epc = h ? {pc[15:8], memf(pc)} : pc + 16'd1; end
    else if (lb)        begin tg = "R4"; ecyc = 2; epc = h ? {memf(pc), memf(pc + 16'd1)} : pc + 16'd2; end
    else if (op == 8'hC4) begin tg = "R6"; ecyc = 2; epc = pc; end
    else                begin tg = "R5"; ecyc = 2; epc = h ? pc + 16'd2 : pc; end
    @(negedge clk);
    start = 1'b1; opcode = op; pc_in = pc;
    flag_q = fl[0]; acc_zero = fl[1]; flag_df = fl[2]; int_en = fl[3]; ext_flag = fl[7:4];
    @(negedge clk);
    start = 1'b0;
    flag_q = ~fl[0]; acc_zero = ~fl[1]; flag_df = ~fl[2]; int_en = ~fl[3]; ext_flag = ~fl[7:4];
    cyc = 0; en0 = 0; en1 = 0; a0 = '0; a1 = '0;
    while (!done && cyc < 5) begin
      if (cyc == 0) begin en0 = rd_en; a0 = rd_addr; end
      if (cyc == 1) begin en1 = rd_en; a1 = rd_addr; end
      cyc++;
      @(negedge clk);
    end
    check(cyc == ecyc, "R7", $sformatf("done delay op %0h", op), cyc, ecyc);
    check(exec_cycles == 2'(ecyc), tg, $sformatf("exec_cycles op %0h", op), exec_cycles, ecyc);
    check(taken == h, "R2", $sformatf("taken op %0h fl %0h", op, fl), taken, h);
    check(pc_out == epc, tg, $sformatf("pc_out op %0h pc %0h fl %0h", op, pc, fl), pc_out, epc);
    if (sh) begin
      check(en0 && a0 == pc, "R3", "read addr", {en0, a0}, {1'b1, pc});
    end else if (lb) begin
      check(en0 && a0 == pc && en1 && a1 == pc + 16'd1, "R4", "read pair",
            {en0, a0, en1, a1}, {1'b1, pc, 1'b1, pc + 16'd1});
    end else begin
      check(!en0 && !en1, tg, "no read on skip/nop", {en0, en1}, 0);
    end
    @(negedge clk);
    check(!done && pc_out == epc, "R7", "hold after pulse", {done, pc_out}, {1'b0, epc});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !rd_en && !taken && pc_out == 0 && exec_cycles == 0, "R1",
          "reset state", {done, rd_en, taken, pc_out, exec_cycles}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !rd_en && !taken && pc_out == 0 && exec_cycles == 0, "R1",
          "after reset", {done, rd_en, taken, pc_out, exec_cycles}, 0);

    // exhaustive sweep: every opcode of both groups under every flag pattern (R2..R7)
    for (int o = 0; o < 32; o++) begin
      for (int f = 0; f < 256; f++) begin
        logic [7:0] op;
        logic [15:0] pc;
        op = (o < 16) ? 8'(8'h30 + o) : 8'(8'hC0 + o - 16);
        pc = {8'(f * 37 + o), 8'(f ^ 8'hF0)};
        run_op(op, pc, 8'(f));
      end
    end

    // wraparound boundaries (R3, R4, R5)
    run_op(8'h38, 16'hFFFF, 8'h00);
    run_op(8'h30, 16'h12FF, 8'h00);
    run_op(8'h31, 16'h12FF, 8'h00);
    run_op(8'hC0, 16'hFFFF, 8'h00);
    run_op(8'hC8, 16'hFFFE, 8'h00);
    run_op(8'hC8, 16'hFFFF, 8'h00);
    run_op(8'hCB, 16'hFFFF, 8'h04);

    // R8: opcodes outside both groups are ignored
    run_op(8'h30, 16'h2222, 8'h00);
    for (int op = 0; op < 256; op++) begin
      if (op[7:4] != 4'h3 && op[7:4] != 4'hC) begin
        bit seen;
        seen = 0;
        @(negedge clk);
        start = 1'b1; opcode = 8'(op); pc_in = 16'h5A5A;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
          if (done || rd_en) seen = 1;
          @(negedge clk);
        end
        check(!seen && pc_out == {8'h22, memf(16'h2222)}, "R8",
              $sformatf("ignored op %0h", op), {seen, pc_out}, {1'b0, 8'h22, memf(16'h2222)});
      end
    end

    // R9: start during a long branch is ignored
    @(negedge clk);
    start = 1'b1; opcode = 8'hC0; pc_in = 16'h4000;
    @(negedge clk);
    opcode = 8'h30; pc_in = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(done && exec_cycles == 2 && pc_out == {memf(16'h4000), memf(16'h4001)}, "R9",
          "busy start ignored", {done, exec_cycles, pc_out},
          {1'b1, 2'd2, memf(16'h4000), memf(16'h4001)});
    begin
      bit extra;
      extra = 0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (done) extra = 1;
      end
      check(!extra, "R9", "no extra done", extra, 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule